// File: doc/BRIEF.md
# Code-Memory Lock Guard

This block protects the on-chip code store of a small microcontroller. Two non-volatile lock bits, held here in a register, select one of four graded protection levels. Each level keeps every restriction of the levels below it. The guard stands between three parties. The first is an external programmer that writes and reads code bytes, the lock bits and a version byte. The second is the CPU, which asks whether a fetch goes to internal or external memory and whether a table-lookup (MOVC-style) read may proceed. The third is the external-access pin, which the block samples while reset is held.

The lock bits are active low, so the erased value of all ones means no protection. A lock write can only clear bits, which means the level can only rise. Only an array erase returns the bits to all ones. The code array is outside the block. The guard drives its write and read strobes and forwards the read byte, or replaces it with 0xFF when access is refused. Fetch qualification is combinational. Programmer responses appear one clock after the request.

Top module: `lock_guard`

## Requirements
- R1: After an array erase pulse, a lock read-back (mode 3'd3) returns the two lock bits in data bits [1:0] with zeros above them, giving 0x03. The protection level is the bitwise inverse of the lock bits: 11 gives level 0, 10 gives level 1, 01 gives level 2 and 00 gives level 3.
- R2: A lock write (mode 3'd2) replaces the lock bits with (old AND data[1:0]), so a bit is never set back to 1. Lock read-back works at every level.
- R3: A code write (mode 3'd0) raises mem_wr_en with address and data passed through only at level 0. At levels 1 to 3 no write strobe is raised, and prog_err is high in the cycle after the request.
- R4: A plain code read (mode 3'd1) raises mem_rd_en and returns mem_rdata one cycle later only at level 0. At any other level there is no read strobe and the result is 0xFF.
- R5: A verification-2 read (mode 3'd5) returns code data at levels 0 and 1, and returns 0xFF without a read strobe at levels 2 and 3.
- R6: A version read (mode 3'd4) returns the VERSION parameter at every level.
- R7: At level 0 the fetch route follows the live external-access pin. A pin value of 0 sends the fetch external.
- R8: At levels 1 and 2 the fetch route uses the pin value last sampled while rst_n was low. Later pin changes have no effect until the next reset.
- R9: A MOVC read (fetch_movc=1) issued from external code (fetch_from_ext=1) that resolves to internal memory is denied at levels 1 to 3 and allowed at level 0. A MOVC read from internal code is never denied.
- R10: At level 3 a latched low pin does not send fetches external. Addresses below the boundary stay internal.
- R11: At every level, an address at or above CODE_BOUND routes external.
- R12: prog_err is raised only in the cycle after a refused code write. Lock writes, reads and accepted writes never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the external-access pin is sampled while low |
| ea_pin | input | 1 | External-access pin (0 selects external code) |
| array_erase | input | 1 | Full erase pulse; restores lock bits to 11 |
| prog_valid | input | 1 | Programmer request strobe |
| prog_mode | input | 3 | 0 write code, 1 read code, 2 write lock, 3 read lock, 4 read version, 5 verify-2 read |
| prog_addr | input | ADDR_W | Programmer byte address |
| prog_wdata | input | DATA_W | Programmer write data |
| prog_rdata | output | DATA_W | Registered read result |
| prog_err | output | 1 | One-cycle refused-write flag |
| mem_wr_en | output | 1 | Code array write strobe |
| mem_rd_en | output | 1 | Code array read strobe |
| mem_addr | output | ADDR_W | Code array address |
| mem_wdata | output | DATA_W | Code array write data |
| mem_rdata | input | DATA_W | Code array read data (combinational from mem_addr) |
| fetch_addr | input | ADDR_W | CPU fetch address |
| fetch_movc | input | 1 | 1 for a MOVC-style data read, 0 for an instruction fetch |
| fetch_from_ext | input | 1 | Issuing code runs from external memory |
| fetch_ext | output | 1 | Fetch routed to external memory |
| fetch_deny | output | 1 | MOVC read refused |

## Verification
Each protection level is reached by erase followed by lock writes, and all six programmer modes are then applied so that level-dependent refusal can be told apart from mode decoding. Lock writes that try to set bits back to 1 show that the level only rises. Fetches are tried below the boundary, at the boundary and one byte under it. The external-access pin is toggled after reset so that the live and latched selections give different routes. MOVC reads are issued from both internal and external code, which separates the source test from the target test.

// File: rtl/lkg_pkg.sv
package lkg_pkg;

   typedef enum logic [2:0] {
      CMD_WR_CODE = 3'd0,
      CMD_RD_CODE = 3'd1,
      CMD_WR_LOCK = 3'd2,
      CMD_RD_LOCK = 3'd3,
      CMD_RD_VER  = 3'd4,
      CMD_VFY2    = 3'd5
   } cmd_e;

   typedef enum logic [1:0] {
      LVL_OPEN    = 2'd0,
      LVL_NOWRITE = 2'd1,
      LVL_NOREAD  = 2'd2,
      LVL_SEALED  = 2'd3
   } lvl_e;

   // lock bits are active low: the level is their inverse
   function automatic lvl_e lock_to_level(input logic [1:0] lk);
      return lvl_e'(~lk);
   endfunction

endpackage

// File: rtl/lkg_lock_store.sv
module lkg_lock_store
   import lkg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       erase,
   input  logic       wr_en,
   input  logic [1:0] wr_bits,
   output logic [1:0] lock_q,
   output lvl_e       level
);

   // non-volatile: not cleared by rst_n, only by erase
   always_ff @(posedge clk) begin
      if (erase)
         lock_q <= 2'b11;
      else if (rst_n && wr_en)
         lock_q <= lock_q & wr_bits;
   end

   assign level = lock_to_level(lock_q);

endmodule

// File: rtl/lkg_prog_gate.sv
module lkg_prog_gate
   import lkg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 8,
   parameter int VERSION = 8'h5C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lvl_e              level,
   input  logic [1:0]        lock_q,
   input  logic              req,
   input  logic [2:0]        mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              err,
   output logic              lock_wr,
   output logic              mem_wr_en,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam logic [DATA_W-1:0] VER_WORD = DATA_W'(VERSION);

   if (DATA_W < 2) begin : g_bad_width
      $error("lkg_prog_gate: DATA_W must hold the two lock bits");
   end

   logic [DATA_W-1:0] lock_word;
   if (DATA_W > 2) begin : g_pad
      assign lock_word = {{(DATA_W-2){1'b0}}, lock_q};
   end else begin : g_nopad
      assign lock_word = lock_q;
   end

   logic wr_ok, rd_ok;
   logic [DATA_W-1:0] rdata_d;

   always_comb begin
      wr_ok = (level == LVL_OPEN);
      unique case (mode)
         CMD_RD_CODE: rd_ok = (level == LVL_OPEN);
         CMD_VFY2:    rd_ok = (level == LVL_OPEN) || (level == LVL_NOWRITE);
         default:     rd_ok = 1'b0;
      endcase
      case (mode)
         CMD_RD_CODE, CMD_VFY2: rdata_d = rd_ok ? mem_rdata : '1;
         CMD_RD_LOCK:           rdata_d = lock_word;
         CMD_RD_VER:            rdata_d = VER_WORD;
         default:               rdata_d = '1;
      endcase
   end

   assign mem_addr  = addr;
   assign mem_wdata = wdata;
   assign mem_wr_en = req && (mode == CMD_WR_CODE) && wr_ok;
   assign mem_rd_en = req && rd_ok;
   assign lock_wr   = req && (mode == CMD_WR_LOCK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err <= req && (mode == CMD_WR_CODE) && !wr_ok;
         if (req)
            rdata <= rdata_d;
      end
   end

endmodule

// File: rtl/lkg_fetch_gate.sv
module lkg_fetch_gate
   import lkg_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CODE_BOUND = 16384
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ea_pin,
   input  lvl_e              level,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_movc,
   input  logic              fetch_from_ext,
   output logic              fetch_ext,
   output logic              fetch_deny
);

   localparam logic [ADDR_W:0] BOUND_W = (ADDR_W+1)'(CODE_BOUND);

   if (CODE_BOUND < 1 || CODE_BOUND > (1 << ADDR_W)) begin : g_bad_bound
      $error("lkg_fetch_gate: CODE_BOUND outside address space");
   end

   logic ea_lat, ea_eff, above;

   // sampled on every clock while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n)
         ea_lat <= ea_pin;
   end

   if (CODE_BOUND == (1 << ADDR_W)) begin : g_full_internal
      assign above = 1'b0;
   end else begin : g_compare
      assign above = ({1'b0, fetch_addr} >= BOUND_W);
   end

   always_comb begin
      unique case (level)
         LVL_OPEN:   ea_eff = ea_pin;
         LVL_SEALED: ea_eff = 1'b1;
         default:    ea_eff = ea_lat;
      endcase
   end

   assign fetch_ext  = above || !ea_eff;
   assign fetch_deny = fetch_movc && fetch_from_ext && !fetch_ext
                       && (level != LVL_OPEN);

endmodule

// File: rtl/lock_guard.sv
module lock_guard
   import lkg_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int CODE_BOUND = 16384,
   parameter int VERSION    = 8'h5C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ea_pin,
   input  logic              array_erase,
   input  logic              prog_valid,
   input  logic [2:0]        prog_mode,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [DATA_W-1:0] prog_wdata,
   output logic [DATA_W-1:0] prog_rdata,
   output logic              prog_err,
   output logic              mem_wr_en,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_movc,
   input  logic              fetch_from_ext,
   output logic              fetch_ext,
   output logic              fetch_deny
);

   logic [1:0] lock_q;
   lvl_e       level;
   logic       lock_wr;
   logic       req;

   assign req = prog_valid && rst_n;

   lkg_lock_store store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .erase   (array_erase),
      .wr_en   (lock_wr),
      .wr_bits (prog_wdata[1:0]),
      .lock_q  (lock_q),
      .level   (level)
   );

   lkg_prog_gate #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .VERSION (VERSION)
   ) prog_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .level     (level),
      .lock_q    (lock_q),
      .req       (req),
      .mode      (prog_mode),
      .addr      (prog_addr),
      .wdata     (prog_wdata),
      .rdata     (prog_rdata),
      .err       (prog_err),
      .lock_wr   (lock_wr),
      .mem_wr_en (mem_wr_en),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   lkg_fetch_gate #(
      .ADDR_W     (ADDR_W),
      .CODE_BOUND (CODE_BOUND)
   ) fetch_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .ea_pin         (ea_pin),
      .level          (level),
      .fetch_addr     (fetch_addr),
      .fetch_movc     (fetch_movc),
      .fetch_from_ext (fetch_from_ext),
      .fetch_ext      (fetch_ext),
      .fetch_deny     (fetch_deny)
   );

endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk #(
   parameter int ADDR_W     = 16,
   parameter int CODE_BOUND = 16384
) (
   input logic              clk,
   input logic              rst_n,
   input logic              array_erase,
   input logic              prog_valid,
   input logic [2:0]        prog_mode,
   input logic              prog_err,
   input logic              mem_wr_en,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              fetch_movc,
   input logic              fetch_from_ext,
   input logic              fetch_ext,
   input logic              fetch_deny,
   input logic [1:0]        lock_q
);

   localparam logic [ADDR_W:0] BOUND_W = (ADDR_W+1)'(CODE_BOUND);

   assert_lock_only_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(array_erase) |-> ((lock_q & ~$past(lock_q)) == 2'b00));

   assert_refused_write_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_valid && prog_mode == 3'd0 && lock_q != 2'b11) |=> prog_err);

   assert_code_read_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_valid && prog_mode == 3'd1 && lock_q != 2'b11) |-> !mem_rd_en);

   assert_movc_denied_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_movc && fetch_from_ext && !fetch_ext && lock_q != 2'b11) |-> fetch_deny);

   assert_sealed_ignores_ea_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q == 2'b00 && {1'b0, fetch_addr} < BOUND_W) |-> !fetch_ext);

   assert_high_addr_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, fetch_addr} >= BOUND_W) |-> fetch_ext);

   assert_err_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
      prog_err |-> ($past(prog_valid) && $past(prog_mode) == 3'd0 && !$past(mem_wr_en)));

endmodule

bind lock_guard lock_guard_chk #(
   .ADDR_W     (ADDR_W),
   .CODE_BOUND (CODE_BOUND)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .array_erase    (array_erase),
   .prog_valid     (prog_valid),
   .prog_mode      (prog_mode),
   .prog_err       (prog_err),
   .mem_wr_en      (mem_wr_en),
   .mem_rd_en      (mem_rd_en),
   .fetch_addr     (fetch_addr),
   .fetch_movc     (fetch_movc),
   .fetch_from_ext (fetch_from_ext),
   .fetch_ext      (fetch_ext),
   .fetch_deny     (fetch_deny),
   .lock_q         (lock_q)
);

// File: tb/lock_guard_tb_top.sv
`timescale 1ns/1ps
module lock_guard_tb_top;

   localparam int ADDR_W = 16;
   localparam int DATA_W = 8;
   localparam int BOUND  = 16384;
   localparam logic [7:0] VER = 8'h5C;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ea_pin = 1'b1;
   logic              array_erase = 1'b0;
   logic              prog_valid = 1'b0;
   logic [2:0]        prog_mode = 3'd0;
   logic [ADDR_W-1:0] prog_addr = '0;
   logic [DATA_W-1:0] prog_wdata = '0;
   logic [DATA_W-1:0] prog_rdata;
   logic              prog_err;
   logic              mem_wr_en, mem_rd_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata;
   logic [ADDR_W-1:0] fetch_addr = '0;
   logic              fetch_movc = 1'b0;
   logic              fetch_from_ext = 1'b0;
   logic              fetch_ext, fetch_deny;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   // code array model: content is a function of the address
   assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

   lock_guard #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_BOUND(BOUND), .VERSION(VER)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .array_erase(array_erase),
      .prog_valid(prog_valid), .prog_mode(prog_mode), .prog_addr(prog_addr),
      .prog_wdata(prog_wdata), .prog_rdata(prog_rdata), .prog_err(prog_err),
      .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .fetch_addr(fetch_addr), .fetch_movc(fetch_movc),
      .fetch_from_ext(fetch_from_ext), .fetch_ext(fetch_ext), .fetch_deny(fetch_deny)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic ea);
      @(negedge clk);
      rst_n  = 1'b0;
      ea_pin = ea;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_erase();
      @(negedge clk);
      array_erase = 1'b1;
      @(negedge clk);
      array_erase = 1'b0;
   endtask

   // drives one request; returns strobes seen before the edge and results after
   task automatic prog_cmd(input logic [2:0] m, input logic [15:0] a, input logic [7:0] d,
                           output logic wr, output logic rd,
                           output logic [7:0] rdat, output logic er);
      @(negedge clk);
      prog_valid = 1'b1;
      prog_mode  = m;
      prog_addr  = a;
      prog_wdata = d;
      #1;
      wr = mem_wr_en;
      rd = mem_rd_en;
      @(negedge clk);
      prog_valid = 1'b0;
      rdat = prog_rdata;
      er   = prog_err;
   endtask

   task automatic fetch_probe(input logic [15:0] a, input logic movc, input logic src_ext,
                              output logic ext, output logic deny);
      @(negedge clk);
      fetch_addr     = a;
      fetch_movc     = movc;
      fetch_from_ext = src_ext;
      #1;
      ext  = fetch_ext;
      deny = fetch_deny;
   endtask

   task automatic t_reset_state();
      do_reset(1'b1);
      check("R12 reset err", {31'd0, prog_err}, 32'd0);
      check("R1 reset rdata", {24'd0, prog_rdata}, 32'd0);
   endtask

   task automatic t_open_level();
      logic wr, rd, er, ext, deny;
      logic [7:0] rv;
      do_erase();
      prog_cmd(3'd3, 16'h0, 8'h0, wr, rd, rv, er);
      check("R1 erased lock", {24'd0, rv}, 32'h03);
      @(negedge clk);
      prog_valid = 1'b1; prog_mode = 3'd0; prog_addr = 16'h0012; prog_wdata = 8'h3C;
      #1;
      check("R3 open write strobe", {31'd0, mem_wr_en}, 32'd1);
      check("R3 open write data", {mem_addr, mem_wdata}, {16'h0012, 8'h3C});
      @(negedge clk);
      prog_valid = 1'b0;
      check("R12 accepted write no err", {31'd0, prog_err}, 32'd0);
      prog_cmd(3'd1, 16'h0034, 8'h0, wr, rd, rv, er);
      check("R4 open read strobe", {31'd0, rd}, 32'd1);
      check("R4 open read data", {24'd0, rv}, 32'h91);
      prog_cmd(3'd5, 16'h0077, 8'h0, wr, rd, rv, er);
      check("R5 open verify2", {24'd0, rv}, {24'd0, 8'h77 ^ 8'hA5});
      prog_cmd(3'd4, 16'h0, 8'h0, wr, rd, rv, er);
      check("R6 open version", {24'd0, rv}, {24'd0, VER});
      ea_pin = 1'b1;
      fetch_probe(16'h0100, 1'b0, 1'b0, ext, deny);
      check("R7 live pin high internal", {31'd0, ext}, 32'd0);
      ea_pin = 1'b0;
      fetch_probe(16'h0100, 1'b0, 1'b0, ext, deny);
      check("R7 live pin low external", {31'd0, ext}, 32'd1);
      ea_pin = 1'b1;
      fetch_probe(16'h0100, 1'b1, 1'b1, ext, deny);
      check("R9 open movc allowed", {31'd0, deny}, 32'd0);
      fetch_probe(16'h5000, 1'b0, 1'b0, ext, deny);
      check("R11 open high addr", {31'd0, ext}, 32'd1);
   endtask

   task automatic t_level1();
      logic wr, rd, er, ext, deny;
      logic [7:0] rv;
      prog_cmd(3'd2, 16'h0, 8'hFE, wr, rd, rv, er);
      check("R12 lock write no err", {31'd0, er}, 32'd0);
      prog_cmd(3'd3, 16'h0, 8'h0, wr, rd, rv, er);
      check("R2 level1 lock", {24'd0, rv}, 32'h02);
      prog_cmd(3'd2, 16'h0, 8'hFF, wr, rd, rv, er);
      prog_cmd(3'd3, 16'h0, 8'h0, wr, rd, rv, er);
      check("R2 set-back ignored", {24'd0, rv}, 32'h02);
      prog_cmd(3'd0, 16'h0012, 8'h55, wr, rd, rv, er);
      check("R3 level1 no write strobe", {31'd0, wr}, 32'd0);
      check("R3 level1 err", {31'd0, er}, 32'd1);
      @(negedge clk);
      check("R12 err one cycle", {31'd0, prog_err}, 32'd0);
      prog_cmd(3'd1, 16'h0034, 8'h0, wr, rd, rv, er);
      check("R4 level1 read strobe", {31'd0, rd}, 32'd0);
      check("R4 level1 read blank", {24'd0, rv}, 32'hFF);
      check("R12 read no err", {31'd0, er}, 32'd0);
      prog_cmd(3'd5, 16'h0034, 8'h0, wr, rd, rv, er);
      check("R5 level1 verify2", {24'd0, rv}, 32'h91);
      prog_cmd(3'd4, 16'h0, 8'h0, wr, rd, rv, er);
      check("R6 level1 version", {24'd0, rv}, {24'd0, VER});
      // latched high from the last reset; live low must not matter
      ea_pin = 1'b0;
      fetch_probe(16'h0100, 1'b0, 1'b0, ext, deny);
      check("R8 latched high holds", {31'd0, ext}, 32'd0);
      do_reset(1'b0);
      prog_cmd(3'd3, 16'h0, 8'h0, wr, rd, rv, er);
      check("R2 lock survives reset", {24'd0, rv}, 32'h02);
      ea_pin = 1'b1;
      fetch_probe(16'h0100, 1'b0, 1'b0, ext, deny);
      check("R8 latched low holds", {31'd0, ext}, 32'd1);
      do_reset(1'b1);
      fetch_probe(16'h0100, 1'b1, 1'b1, ext, deny);
      check("R9 level1 movc from ext denied", {31'd0, deny}, 32'd1);
      fetch_probe(16'h0100, 1'b1, 1'b0, ext, deny);
      check("R9 movc from internal allowed", {31'd0, deny}, 32'd0);
      fetch_probe(16'h4100, 1'b1, 1'b1, ext, deny);
      check("R9 movc to external allowed", {31'd0, deny}, 32'd0);
   endtask

   task automatic t_level2();
      logic wr, rd, er;
      logic [7:0] rv;
      do_erase();
      prog_cmd(3'd2, 16'h0, 8'h01, wr, rd, rv, er);
      prog_cmd(3'd3, 16'h0, 8'h0, wr, rd, rv, er);
      check("R1 level2 lock", {24'd0, rv}, 32'h01);
      prog_cmd(3'd5, 16'h0034, 8'h0, wr, rd, rv, er);
      check("R5 level2 verify2 strobe", {31'd0, rd}, 32'd0);
      check("R5 level2 verify2 blank", {24'd0, rv}, 32'hFF);
      prog_cmd(3'd1, 16'h0034, 8'h0, wr, rd, rv, er);
      check("R4 level2 read blank", {24'd0, rv}, 32'hFF);
      prog_cmd(3'd0, 16'h0001, 8'h00, wr, rd, rv, er);
      check("R3 level2 err", {31'd0, er}, 32'd1);
   endtask

   task automatic t_level3();
      logic wr, rd, er, ext, deny;
      logic [7:0] rv;
      prog_cmd(3'd2, 16'h0, 8'h00, wr, rd, rv, er);
      prog_cmd(3'd3, 16'h0, 8'h0, wr, rd, rv, er);
      check("R2 level3 lock", {24'd0, rv}, 32'h00);
      do_reset(1'b0);
      fetch_probe(16'h0100, 1'b0, 1'b0, ext, deny);
      check("R10 sealed pin low internal", {31'd0, ext}, 32'd0);
      fetch_probe(16'h3FFF, 1'b0, 1'b0, ext, deny);
      check("R11 just below bound", {31'd0, ext}, 32'd0);
      fetch_probe(16'h4000, 1'b0, 1'b0, ext, deny);
      check("R11 at bound", {31'd0, ext}, 32'd1);
      fetch_probe(16'h0200, 1'b1, 1'b1, ext, deny);
      check("R9 level3 movc denied", {31'd0, deny}, 32'd1);
      prog_cmd(3'd4, 16'h0, 8'h0, wr, rd, rv, er);
      check("R6 level3 version", {24'd0, rv}, {24'd0, VER});
      prog_cmd(3'd5, 16'h0034, 8'h0, wr, rd, rv, er);
      check("R5 level3 verify2 blank", {24'd0, rv}, 32'hFF);
   endtask

   initial begin
      t_reset_state();
      t_open_level();
      t_level1();
      t_level2();
      t_level3();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule